// File: doc/BRIEF.md
# Big-Endian Byte and Word Access Aligner

This block sits between the load/store stage of a core and a data memory that is one word wide. It takes a byte address, an access size (one byte or one full word), a write flag and the register value being stored. It returns the word address for the memory, the write data moved into the right byte lane, a per-lane byte-enable mask and a gated write strobe. For a load, it takes the word the memory returns and either passes it through unchanged or picks out the addressed byte and sign-extends it to the full register width.

Lanes are numbered big-endian. Byte offset 0 names the most significant lane of the word and the highest offset names the least significant lane. A byte always moves through the low eight bits of the register. A word access whose address is not a multiple of the word size raises a misalignment flag, and no write strobe or byte enable is sent for it. The block is purely combinational, so the memory sees its outputs in the same cycle the request is presented.

Top module: `be_lsu_align`

## Requirements
- R1: The word address output equals the byte address with its two low bits dropped, for every access size and every offset.
- R2: A valid byte access drives exactly one byte-enable bit. Offset 0 drives bit 3, offset 1 drives bit 2, offset 2 drives bit 1 and offset 3 drives bit 0.
- R3: For a byte access, the selected lane of the write data carries bits 7:0 of the store value. Offset 0 maps to bits 31:24 and offset 3 maps to bits 7:0. Every other lane is zero.
- R4: A byte store changes only the addressed byte of the memory word. The other three bytes keep their earlier contents.
- R5: A byte load returns the addressed lane of the read word in bits 7:0, using the R3 offset-to-lane mapping, with bit 7 copied into bits 31:8.
- R6: An aligned word access drives all four byte-enable bits and passes the store value to the write data unchanged.
- R7: A word load returns the read word unchanged.
- R8: A valid word access whose address bits 1:0 are not 00 sets the misalign flag, holds the write strobe low and drives no byte enable. A byte access never sets the flag.
- R9: While no access is valid, the write strobe, byte enables and misalign flag are all low, and memory is not modified.
- R10: The write strobe is high only for a valid, aligned store. A load (write flag low) never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_word | input | 1 | 1 = full-word access, 0 = single-byte access |
| acc_addr | input | 32 | Byte address of the access |
| st_data | input | 32 | Register value to store (a byte uses bits 7:0) |
| mem_rdata | input | 32 | Word returned by the memory at mem_waddr |
| mem_waddr | output | 30 | Word address sent to the memory |
| mem_wdata | output | 32 | Write data with the byte placed in its lane |
| mem_be | output | 4 | Byte-enable mask, bit 3 = most significant lane |
| mem_we | output | 1 | Write strobe for the memory |
| ld_data | output | 32 | Load result, sign-extended for byte loads |
| misalign | output | 1 | Word access not on a word boundary |

## Verification
The hardest case to reach from the ports is the proof that a byte store leaves its three neighbours untouched (R4). The aligner never sees the memory contents, so a wrong enable mask or leakage into a nearby lane shows up only later, when the word is read back. The bench first fills words with distinct byte patterns using word stores. It then writes single bytes at each offset and reads every word back through word loads, comparing against its own model memory. The sign-extension check uses bytes with bit 7 set and clear in the same word, read at every offset, so a lane swap changes the upper bits as well as the low byte.

// File: rtl/be_align_pkg.sv
package be_align_pkg;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } acc_size_e;

  // Big-endian: offset k lands in lane (lanes-1-k), lane 0 being the least significant.
  function automatic int lane_of_offset(input int off, input int lanes);
    return lanes - 1 - off;
  endfunction

  // Copy the top bit of a narrow value into every higher bit.
  function automatic logic [63:0] sext_from(input logic [63:0] v, input int width);
    logic [63:0] r;
    for (int b = 0; b < 64; b++) begin
      r[b] = (b < width) ? v[b] : v[width-1];
    end
    return r;
  endfunction

endpackage

// File: rtl/be_lane_decode.sv
module be_lane_decode #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] offset,
  input  logic             byte_mode,
  input  logic             active,
  output logic [LANES-1:0] lane_sel,
  output logic [LANES-1:0] be
);
  import be_align_pkg::*;

  for (genvar i = 0; i < LANES; i++) begin : g_sel
    assign lane_sel[i] = (int'(offset) == lane_of_offset(i, LANES));
  end

  always_comb begin
    if (!active)        be = '0;
    else if (byte_mode) be = lane_sel;
    else                be = '1;
  end
endmodule

// File: rtl/be_store_steer.sv
module be_store_steer #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [LANES-1:0]  lane_sel,
  input  logic              byte_mode,
  input  logic [DATA_W-1:0] st_data,
  output logic [DATA_W-1:0] wdata
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      if (!byte_mode)      wdata[i*LANE_W +: LANE_W] = st_data[i*LANE_W +: LANE_W];
      else if (lane_sel[i]) wdata[i*LANE_W +: LANE_W] = st_data[LANE_W-1:0];
      else                 wdata[i*LANE_W +: LANE_W] = '0;
    end
  end
endmodule

// File: rtl/be_load_extract.sv
module be_load_extract #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [LANES-1:0]  lane_sel,
  input  logic              byte_mode,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ld_data
);
  import be_align_pkg::*;

  logic [LANE_W-1:0] picked;
  logic [63:0]       widened;

  always_comb begin
    picked = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_sel[i]) picked = picked | rdata[i*LANE_W +: LANE_W];
    end
  end

  assign widened = sext_from(64'(picked), LANE_W);
  assign ld_data = byte_mode ? widened[DATA_W-1:0] : rdata;
endmodule

// File: rtl/be_lsu_align.sv
module be_lsu_align #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 32,
  localparam int DATA_W  = LANES * LANE_W,
  localparam int OFF_W   = $clog2(LANES),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic               acc_word,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [DATA_W-1:0]  st_data,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [WADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [LANES-1:0]   mem_be,
  output logic               mem_we,
  output logic [DATA_W-1:0]  ld_data,
  output logic               misalign
);
  import be_align_pkg::*;

  acc_size_e        size;
  logic             byte_mode;
  logic [OFF_W-1:0] offset;
  logic             off_nonzero;
  logic             access_ok;
  logic [LANES-1:0] lane_sel;

  assign size        = acc_size_e'(acc_word);
  assign byte_mode   = (size == SZ_BYTE);
  assign offset      = acc_addr[OFF_W-1:0];
  assign off_nonzero = |offset;
  assign misalign    = acc_valid && !byte_mode && off_nonzero;
  assign access_ok   = acc_valid && !misalign;
  assign mem_waddr   = acc_addr[ADDR_W-1:OFF_W];
  assign mem_we      = access_ok && acc_write;

  be_lane_decode #(.LANES(LANES)) u_dec (
    .offset    (offset),
    .byte_mode (byte_mode),
    .active    (access_ok),
    .lane_sel  (lane_sel),
    .be        (mem_be)
  );

  be_store_steer #(.LANES(LANES), .LANE_W(LANE_W)) u_st (
    .lane_sel  (lane_sel),
    .byte_mode (byte_mode),
    .st_data   (st_data),
    .wdata     (mem_wdata)
  );

  be_load_extract #(.LANES(LANES), .LANE_W(LANE_W)) u_ld (
    .lane_sel  (lane_sel),
    .byte_mode (byte_mode),
    .rdata     (mem_rdata),
    .ld_data   (ld_data)
  );
endmodule

// File: rtl/be_lsu_align_chk.sv
module be_lsu_align_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input logic              acc_valid,
  input logic              acc_write,
  input logic              acc_word,
  input logic [DATA_W-1:0] st_data,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [LANES-1:0]  mem_be,
  input logic              mem_we,
  input logic [DATA_W-1:0] ld_data,
  input logic              misalign
);
  always_comb begin
    // R2
    byte_be_onehot_chk: assert (!(acc_valid && !acc_word) || $countones(mem_be) == 1)
      else $error("byte access without a single lane enable");
    // R8
    misalign_quiet_chk: assert (!misalign || (!mem_we && mem_be == '0))
      else $error("misaligned access still enabled memory");
    // R8
    byte_never_misalign_chk: assert (acc_word || !misalign)
      else $error("byte access flagged misaligned");
    // R9
    idle_quiet_chk: assert (acc_valid || (!mem_we && mem_be == '0 && !misalign))
      else $error("idle cycle drove memory controls");
    // R10
    load_no_write_chk: assert (!mem_we || (acc_write && acc_valid))
      else $error("write strobe without a valid store");
    // R5
    byte_sext_chk: assert (acc_word ||
        ld_data[DATA_W-1:LANE_W] == {(DATA_W-LANE_W){ld_data[LANE_W-1]}})
      else $error("byte load not sign-extended");
  end

  // R3
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_copy_chk: assert (!(acc_valid && !acc_word && mem_be[i]) ||
                             mem_wdata[i*LANE_W +: LANE_W] == st_data[LANE_W-1:0])
        else $error("enabled lane does not hold the store byte");
    end
  end
endmodule

bind be_lsu_align be_lsu_align_chk #(.LANES(LANES), .LANE_W(LANE_W)) chk_i (
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_word  (acc_word),
  .st_data   (st_data),
  .mem_wdata (mem_wdata),
  .mem_be    (mem_be),
  .mem_we    (mem_we),
  .ld_data   (ld_data),
  .misalign  (misalign)
);

// File: tb/be_lsu_align_test.sv
module be_lsu_align_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_word = 1'b0;
  logic [31:0] acc_addr = '0, st_data = '0;
  logic [31:0] mem_rdata;
  logic [29:0] mem_waddr;
  logic [31:0] mem_wdata, ld_data;
  logic [3:0]  mem_be;
  logic        mem_we, misalign;

  be_lsu_align uut (
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_word(acc_word),
    .acc_addr(acc_addr), .st_data(st_data), .mem_rdata(mem_rdata),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_we(mem_we), .ld_data(ld_data), .misalign(misalign)
  );

  // Byte-enable memory driven by the design's outputs.
  logic [31:0] mem [16];
  // Model memory updated only by the bench's own rules.
  logic [31:0] ref_mem [16];
  int checks = 0, fails = 0;
  bit done = 0;

  assign mem_rdata = mem[mem_waddr[3:0]];

  always @(posedge clk) begin
    if (mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_waddr[3:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit v, input bit wr, input bit wd,
                        input logic [31:0] a, input logic [31:0] d);
    int off, sh, idx;
    bit mis, en;
    logic [31:0] e_wdata, e_ld, word;
    logic [3:0]  e_be;
    logic [7:0]  bt;
    @(negedge clk);
    acc_valid = v; acc_write = wr; acc_word = wd; acc_addr = a; st_data = d;
    #1;
    off = int'(a % 4);
    sh  = 8 * (3 - off);
    idx = int'((a / 4) % 16);
    mis = v && wd && (off != 0);
    en  = v && !mis;
    word = ref_mem[idx];
    if (wd) begin
      e_wdata = d;
      e_be    = en ? 4'hF : 4'h0;
      e_ld    = word;
    end else begin
      e_wdata = (d & 32'hFF) << sh;
      e_be    = en ? (4'b1 << (3 - off)) : 4'h0;
      bt      = 8'((word >> sh) & 32'hFF);
      e_ld    = 32'($signed(bt));
    end
    chk("R1", "waddr", {2'b00, mem_waddr}, a >> 2);
    chk(wd ? "R6" : "R2", "be", {28'd0, mem_be}, {28'd0, e_be});
    chk(wd ? "R6" : "R3", "wdata", mem_wdata, e_wdata);
    chk("R8", "misalign", {31'd0, misalign}, {31'd0, mis});
    chk(v ? "R10" : "R9", "we", {31'd0, mem_we}, {31'd0, en && wr});
    if (v && !wr && en) chk(wd ? "R7" : "R5", "ld_data", ld_data, e_ld);
    if (en && wr) begin
      if (wd) ref_mem[idx] = d;
      else    ref_mem[idx][sh +: 8] = d[7:0];
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h0;
      ref_mem[i] = 32'h0;
    end
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R9: idle reset state
    @(negedge clk); #1;
    chk("R9", "idle be", {28'd0, mem_be}, 32'd0);
    chk("R9", "idle we", {31'd0, mem_we}, 32'd0);
    chk("R9", "idle misalign", {31'd0, misalign}, 32'd0);
    // R6: aligned word fills
    access(1, 1, 1, 32'h0, 32'h11223344);
    access(1, 1, 1, 32'h4, 32'h55667788);
    access(1, 1, 1, 32'h8, 32'h807FFF01);
    access(1, 1, 1, 32'hC, 32'hCAFEF00D);
    // R2 R3: byte stores at every offset, junk in the upper register bits
    access(1, 1, 0, 32'h0, 32'hDEADBEA1);
    access(1, 1, 0, 32'h1, 32'h123456B2);
    access(1, 1, 0, 32'h2, 32'hFFFFFFC3);
    access(1, 1, 0, 32'h3, 32'h000000D4);
    // R4: one byte into word 1 only
    access(1, 1, 0, 32'h6, 32'hAAAAAA99);
    // R5: byte loads with both sign values at every offset
    for (int k = 0; k < 4; k++) access(1, 0, 0, 32'h8 + k, 32'h0);
    for (int k = 0; k < 4; k++) access(1, 0, 0, 32'h4 + k, 32'h0);
    // R7: word loads
    access(1, 0, 1, 32'h0, 32'h0);
    access(1, 0, 1, 32'hC, 32'h0);
    // R8: misaligned word stores and loads
    for (int k = 1; k < 4; k++) access(1, 1, 1, 32'h4 + k, 32'h0BADBAD0);
    access(1, 0, 1, 32'h9, 32'h0);
    // R10: loads never write
    access(1, 0, 0, 32'hD, 32'hFFFFFFFF);
    // R1: high address bits
    access(1, 1, 0, 32'hFFFF_FFF2, 32'h0000005A);
    access(1, 1, 1, 32'h8000_0010, 32'h01020304);
    // R9: store request without valid
    access(0, 1, 1, 32'h0, 32'hFFFFFFFF);
    access(0, 1, 0, 32'h5, 32'hFFFFFFFF);
    // R4: read back every word through the ports
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      acc_valid = 1; acc_write = 0; acc_word = 1; acc_addr = 32'(i * 4);
      #1;
      chk("R4", "readback", ld_data, ref_mem[i]);
    end
    @(negedge clk);
    acc_valid = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule